// File: doc/BRIEF.md
# Palette Lookup Table with Component Write Sequencer

The block holds a 256-entry colour table, each entry a red, green and blue byte. Software fills the table through a small register window: one register selects the entry to program, and a second register accepts colour components. A sequencer inside the block sends each arriving component to red, then green, then blue of the selected entry. After blue it moves on to the next entry, so a whole palette can be loaded as one stream of bytes.

A data write can be one byte wide or 32 bits wide. A wide write counts as four component writes in one cycle, taken from the top byte down. A separate lookup port serves the pixel path. An 8-bit pixel value goes in and the 24-bit colour of that entry comes out one cycle later. A redraw-request flag tells the display side that the palette has changed. The display side clears it with an acknowledge pulse.

Top module: `palette_lut`

## Requirements
- R1: After reset every entry reads back as zero on the lookup port, the sequencer is in the red state, and redraw_req is 1.
- R2: A write to offset 0x00 loads the selected entry from bus_wdata[7:0] and puts the sequencer in the red state.
- R3: A byte write (bus_wide=0) to offset 0x04 stores bus_wdata[7:0] into the current component of the selected entry. Successive component writes go to red, then green, then blue.
- R4: After a blue component is stored, the selected entry advances by one modulo 256 and the sequencer returns to red.
- R5: A wide write (bus_wide=1) to offset 0x04 acts as four component writes in one cycle, in the order bus_wdata[31:24], [23:16], [15:8], [7:0]. Each one advances the sequencer, and the write may span two entries.
- R6: pix_rgb shows the entry selected by pix_idx one clock after pix_idx is sampled, packed as red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R7: A lookup of an entry that is written in the same cycle returns the value the entry held before that write.
- R8: Any write to offset 0x04 sets redraw_req. A redraw_ack pulse clears it. When a write and an ack arrive in the same cycle, the flag stays set.
- R9: Writes to any offset other than 0x00 and 0x04 change neither the table, the sequencer nor redraw_req.
- R10: A write to offset 0x00 part-way through a red/green/blue group abandons that group, and the next component goes to red of the newly selected entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wide | input | 1 | 1: 32-bit data write, 0: byte write using bits 7:0 |
| pix_idx | input | 8 | Pixel value to look up |
| pix_rgb | output | 24 | Registered colour of the looked-up entry |
| redraw_ack | input | 1 | Display side has consumed the redraw request |
| redraw_req | output | 1 | Palette changed since the last acknowledge |

## Verification
The hardest case to reach from the ports is a wide write that starts on the green or blue state. Its four components then split across two entries, and when it starts at blue the selected entry advances by two. The stimulus reaches this by leaving the sequencer at each state with one or two byte writes before a wide write. It also lines a wide write up with entry 255, so the advance wraps to entry 0. Same-cycle write and lookup of one entry, and ack colliding with a write, are driven as single combined cycles.

// File: rtl/palette_pkg.sv
package palette_pkg;
  typedef enum logic [1:0] {
    C_RED = 2'd0,
    C_GRN = 2'd1,
    C_BLU = 2'd2
  } comp_e;
endpackage

// File: rtl/palette_seq.sv
module palette_seq
  import palette_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int IDX_OFF = 0,
  parameter int MAP_OFF = 4,
  localparam int SLOTS = DATA_W / 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          wide,
  output logic                          map_wr,
  output logic [SLOTS-1:0]              slot_vld,
  output logic [SLOTS-1:0][1:0]         slot_comp,
  output logic [SLOTS-1:0][IDX_W-1:0]   slot_idx,
  output logic [SLOTS-1:0][7:0]         slot_byte
);

  comp_e             comp_q, comp_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_wr;
  logic [3:0]        cnt, tot, tmod, tdiv;

  assign idx_wr = wr_en && (addr == ADDR_W'(IDX_OFF));
  assign map_wr = wr_en && (addr == ADDR_W'(MAP_OFF));
  assign cnt    = wide ? 4'(SLOTS) : 4'd1;
  assign tot    = {2'b00, comp_q} + cnt;
  assign tmod   = tot % 4'd3;
  assign tdiv   = tot / 4'd3;

  always_comb begin
    comp_d = comp_q;
    idx_d  = idx_q;
    if (idx_wr) begin
      idx_d  = wdata[IDX_W-1:0];
      comp_d = C_RED;
    end else if (map_wr) begin
      comp_d = comp_e'(tmod[1:0]);
      idx_d  = idx_q + IDX_W'(tdiv);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_q <= C_RED;
      idx_q  <= '0;
    end else if (idx_wr || map_wr) begin
      comp_q <= comp_d;
      idx_q  <= idx_d;
    end
  end

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    logic [3:0] pos;
    logic       wrap;
    assign pos  = {2'b00, comp_q} + 4'(j);
    assign wrap = pos >= 4'd3;
    assign slot_vld[j]  = map_wr && (wide || (j == 0));
    assign slot_comp[j] = wrap ? 2'(pos - 4'd3) : pos[1:0];
    assign slot_idx[j]  = idx_q + IDX_W'(wrap);
    assign slot_byte[j] = wide ? wdata[DATA_W-1-8*j -: 8] : wdata[7:0];
  end

  p_comp_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    comp_q != 2'd3);

  p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (idx_q == $past(wdata[IDX_W-1:0])) && (comp_q == C_RED));

  p_blue_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (map_wr && !wide && comp_q == C_BLU) |=>
      (idx_q == $past(idx_q) + 1'b1) && (comp_q == C_RED));

  p_word_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (map_wr && wide) |=>
      (($past(comp_q) == C_BLU) ? (idx_q == $past(idx_q) + 2'd2)
                                : (idx_q == $past(idx_q) + 2'd1)));
endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int SLOTS = 4,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SLOTS-1:0]              slot_vld,
  input  logic [SLOTS-1:0][1:0]         slot_comp,
  input  logic [SLOTS-1:0][IDX_W-1:0]   slot_idx,
  input  logic [SLOTS-1:0][7:0]         slot_byte,
  input  logic [IDX_W-1:0]              pix_idx,
  output logic [23:0]                   pix_rgb
);

  logic [7:0]  red_q [DEPTH];
  logic [7:0]  grn_q [DEPTH];
  logic [7:0]  blu_q [DEPTH];
  logic [23:0] rgb_d, rgb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        red_q[e] <= '0;
        grn_q[e] <= '0;
        blu_q[e] <= '0;
      end
    end else begin
      for (int j = 0; j < SLOTS; j++) begin
        if (slot_vld[j]) begin
          case (slot_comp[j])
            C_RED:   red_q[slot_idx[j]] <= slot_byte[j];
            C_GRN:   grn_q[slot_idx[j]] <= slot_byte[j];
            default: blu_q[slot_idx[j]] <= slot_byte[j];
          endcase
        end
      end
    end
  end

  assign rgb_d = {red_q[pix_idx], grn_q[pix_idx], blu_q[pix_idx]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rgb_q <= '0;
    else        rgb_q <= rgb_d;
  end

  assign pix_rgb = rgb_q;

  p_slot_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld[SLOTS-1] |-> (slot_idx[SLOTS-1] == slot_idx[0] + 1'b1)
                          && (slot_comp[SLOTS-1] == slot_comp[0]));
endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import palette_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  localparam int SLOTS = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wide,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [23:0]       pix_rgb,
  input  logic              redraw_ack,
  output logic              redraw_req
);

  logic [1:0]                   rst_sync_q;
  logic                         rst_sync_n;
  logic                         map_wr;
  logic [SLOTS-1:0]             slot_vld;
  logic [SLOTS-1:0][1:0]        slot_comp;
  logic [SLOTS-1:0][IDX_W-1:0]  slot_idx;
  logic [SLOTS-1:0][7:0]        slot_byte;
  logic                         redraw_d, redraw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  palette_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .wide      (bus_wide),
    .map_wr    (map_wr),
    .slot_vld  (slot_vld),
    .slot_comp (slot_comp),
    .slot_idx  (slot_idx),
    .slot_byte (slot_byte)
  );

  palette_store #(
    .IDX_W (IDX_W),
    .SLOTS (SLOTS)
  ) i_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .slot_vld  (slot_vld),
    .slot_comp (slot_comp),
    .slot_idx  (slot_idx),
    .slot_byte (slot_byte),
    .pix_idx   (pix_idx),
    .pix_rgb   (pix_rgb)
  );

  always_comb begin
    redraw_d = redraw_q;
    if (map_wr)          redraw_d = 1'b1;
    else if (redraw_ack) redraw_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) redraw_q <= 1'b1;
    else             redraw_q <= redraw_d;
  end

  assign redraw_req = redraw_q;

  p_redraw_set_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    map_wr |=> redraw_req);

  p_redraw_clr_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (redraw_ack && !bus_wr) |=> !redraw_req);

  p_redraw_keep_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!map_wr && !redraw_ack) |=> $stable(redraw_req));
endmodule

// File: tb/test_palette_lut.sv
module test_palette_lut;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wide;
  logic [7:0]  pix_idx;
  logic [23:0] pix_rgb;
  logic        redraw_ack;
  logic        redraw_req;

  always #4 clk = ~clk;

  palette_lut i_palette_lut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wide   (bus_wide),
    .pix_idx    (pix_idx),
    .pix_rgb    (pix_rgb),
    .redraw_ack (redraw_ack),
    .redraw_req (redraw_req)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  logic [7:0] m_idx;
  int         m_c;
  logic       m_red;

  logic [23:0] exp_q [$];
  string       tag_q [$];
  logic        lk_vld = 1'b0;
  logic        pend   = 1'b0;

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() != 0) begin
        chk(tag_q.pop_front(), pix_rgb, exp_q.pop_front());
      end
    end
    pend = lk_vld;
  end

  task automatic model_write(input logic [4:0] a, input logic [31:0] d, input logic wide);
    if (a == 5'h00) begin
      m_idx = d[7:0];
      m_c   = 0;
    end else if (a == 5'h04) begin
      for (int k = 0; k < (wide ? 4 : 1); k++) begin
        logic [7:0] bv;
        bv = wide ? d[31-8*k -: 8] : d[7:0];
        case (m_c)
          0: m_r[m_idx] = bv;
          1: m_g[m_idx] = bv;
          default: m_b[m_idx] = bv;
        endcase
        if (m_c == 2) begin
          m_idx = m_idx + 8'd1;
          m_c   = 0;
        end else begin
          m_c++;
        end
      end
      m_red = 1'b1;
    end
  endtask

  task automatic step(input logic wr, input logic [4:0] a, input logic [31:0] d,
                      input logic wide, input logic lk, input logic [7:0] li,
                      input logic ack, input string tag);
    bus_wr     = wr;
    bus_addr   = a;
    bus_wdata  = d;
    bus_wide   = wide;
    pix_idx    = li;
    lk_vld     = lk;
    redraw_ack = ack;
    if (lk) begin
      exp_q.push_back({m_r[li], m_g[li], m_b[li]});
      tag_q.push_back(tag);
    end
    if (wr) model_write(a, d, wide);
    if (!(wr && a == 5'h04) && ack) m_red = 1'b0;
    @(posedge clk);
    #2;
    bus_wr     = 1'b0;
    lk_vld     = 1'b0;
    redraw_ack = 1'b0;
  endtask

  task automatic wr_idx(input logic [7:0] v);
    step(1'b1, 5'h00, {24'h0, v}, 1'b0, 1'b0, 8'h0, 1'b0, "R2");
  endtask

  task automatic wr_byte(input logic [7:0] v);
    step(1'b1, 5'h04, {24'hFFFFFF, v}, 1'b0, 1'b0, 8'h0, 1'b0, "R3");
  endtask

  task automatic wr_word(input logic [31:0] v);
    step(1'b1, 5'h04, v, 1'b1, 1'b0, 8'h0, 1'b0, "R5");
  endtask

  task automatic look(input logic [7:0] li, input string tag);
    step(1'b0, 5'h00, 32'h0, 1'b0, 1'b1, li, 1'b0, tag);
  endtask

  task automatic drain;
    repeat (3) @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%06h expected=%06h", 24'h0, 24'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 256; e++) begin
      m_r[e] = 8'h0; m_g[e] = 8'h0; m_b[e] = 8'h0;
    end
    m_idx = 8'h0; m_c = 0; m_red = 1'b1;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    bus_wide = 1'b0; pix_idx = '0; redraw_ack = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;

    // R1: reset state
    chk("R1", {23'h0, redraw_req}, 24'h1);
    look(8'h00, "R1");
    look(8'hFF, "R1");
    look(8'h4D, "R1");
    drain();
    // R1: sequencer starts at red of entry 0
    wr_byte(8'h5A);
    look(8'h00, "R1");
    drain();

    // R8: ack clears
    step(1'b0, 5'h00, 32'h0, 1'b0, 1'b0, 8'h0, 1'b1, "R8");
    chk("R8", {23'h0, redraw_req}, {23'h0, m_red});

    // R2, R3, R6: byte group
    wr_idx(8'd10);
    wr_byte(8'h11);
    wr_byte(8'h22);
    wr_byte(8'h33);
    chk("R8", {23'h0, redraw_req}, 24'h1);
    look(8'd10, "R3_R6");
    // R4: next byte lands on red of entry 11
    wr_byte(8'h44);
    look(8'd11, "R4");
    drain();

    // R4: wrap 255 -> 0
    wr_idx(8'hFF);
    wr_byte(8'hA0); wr_byte(8'hA1); wr_byte(8'hA2);
    wr_byte(8'hB0);
    look(8'hFF, "R4");
    look(8'h00, "R4");
    drain();

    // R5: wide write from red
    wr_idx(8'd20);
    wr_word(32'hA1B2C3D4);
    look(8'd20, "R5");
    look(8'd21, "R5");
    // R5: continue from green of 21
    wr_word(32'h01020304);
    look(8'd21, "R5");
    look(8'd22, "R5");
    drain();
    // R5: wide write starting at blue, wrapping past 255
    wr_idx(8'hFE);
    wr_byte(8'h70); wr_byte(8'h71);
    wr_word(32'hC0C1C2C3);
    wr_byte(8'h99);
    look(8'hFE, "R5");
    look(8'hFF, "R5");
    look(8'h00, "R5");
    drain();

    // R10: index write mid-group restarts at red
    wr_idx(8'd40);
    wr_byte(8'h55);
    wr_idx(8'd41);
    wr_byte(8'h66); wr_byte(8'h77);
    look(8'd40, "R10");
    look(8'd41, "R10");
    drain();

    // R9: other offsets ignored
    step(1'b0, 5'h00, 32'h0, 1'b0, 1'b0, 8'h0, 1'b1, "R9");
    step(1'b1, 5'h10, 32'hDEADBEEF, 1'b1, 1'b0, 8'h0, 1'b0, "R9");
    step(1'b1, 5'h08, 32'h12345678, 1'b0, 1'b0, 8'h0, 1'b0, "R9");
    chk("R9", {23'h0, redraw_req}, 24'h0);
    wr_byte(8'h88);
    look(8'd41, "R9");
    look(8'hEF, "R9");
    drain();

    // R7: same-cycle write and lookup see old value
    wr_idx(8'd10);
    step(1'b1, 5'h04, 32'h000000EE, 1'b0, 1'b1, 8'd10, 1'b0, "R7");
    look(8'd10, "R7");
    drain();

    // R8: write and ack together keep the flag
    step(1'b1, 5'h04, 32'h0000001F, 1'b0, 1'b0, 8'h0, 1'b1, "R8");
    chk("R8", {23'h0, redraw_req}, 24'h1);
    drain();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule